// File: doc/BRIEF.md
# Sequential Rotate-Right Unit

This block is a multi-cycle execution unit that rotates an operand to the right, one bit position per clock, inside a small processor datapath. On each step the bit that leaves the bottom of the operand goes back in at the top of the selected width, and it is also copied into the carry flag. No carry-in path exists, so no bit is ever lost. The operand width is 8, 16 or 32 bits. The amount is either a fixed single position or a value taken from a count input, and a mode bit picks between the two.

The issuing logic pulses `start` with the operand, the width, the mode, the count, an indication of whether the destination is an immediate, and the five incoming flags. The unit captures all of these in the same clock. It then runs for as many cycles as the masked count, and after that it raises `done` for one cycle. The result and the flags stay stable while `done` is high. The sign, parity and zero flags come back exactly as they went in. Overflow is recomputed only for a one-position rotate. An immediate destination is rejected: the unit flags an error and changes nothing.

Top module: `rotr_seq_unit`

## Requirements
- R1: The result equals the captured operand rotated right by N positions within the selected width. On every position the least significant bit moves to the top bit of the width and all other bits move down by one.
- R2: With `by_count` = 0, N is 1 and `cnt_in` is ignored. With `by_count` = 1, N is `cnt_in[4:0]`, and bits 7:5 of `cnt_in` have no effect.
- R3: For N > 0 the carry output equals the last bit rotated out, which is the top bit of the result within the width. For N = 0 the carry output equals the captured carry input.
- R4: For N = 1 the overflow output is the XOR of the two highest bits of the result within the width. In every other case it equals the captured overflow input.
- R5: The sign, parity and zero outputs equal the values of `sf_in`, `pf_in` and `zf_in` that were captured with `start`. Later changes on those inputs have no effect.
- R6: `size_sel` encodes 00 = 8 bits, 01 = 16 bits, and 10 or 11 = 32 bits. Result bits above the selected width read as zero.
- R7: When N = 0, `done` rises on the same edge that accepts `start`. The result is the operand limited to the width, and all five flags equal the captured inputs.
- R8: For N > 0, `done` rises at the N-th clock edge after the edge that accepted `start`. `done` stays high for exactly one cycle.
- R9: `start` is accepted only while `busy` is low. `busy` is high from acceptance through the `done` cycle, and a `start` during that interval has no effect on the result.
- R10: When `dst_imm` = 1 at acceptance, `illegal` and `done` rise on the accepting edge. The result is the operand limited to the width, and all flags equal their inputs. `illegal` is 0 for every other operation.
- R11: After reset, `busy`, `done`, `illegal`, `res_out` and all flag outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Operation request, captured when idle |
| opnd_in | input | 32 | Operand to rotate |
| size_sel | input | 2 | Width select (00 = 8, 01 = 16, 1x = 32) |
| by_count | input | 1 | 0 = one position, 1 = use `cnt_in` |
| cnt_in | input | 8 | Count value; only bits 4:0 are used |
| dst_imm | input | 1 | Destination is an immediate (illegal) |
| cf_in | input | 1 | Incoming carry flag |
| of_in | input | 1 | Incoming overflow flag |
| sf_in | input | 1 | Incoming sign flag |
| pf_in | input | 1 | Incoming parity flag |
| zf_in | input | 1 | Incoming zero flag |
| busy | output | 1 | Operation in progress, including the done cycle |
| done | output | 1 | One-cycle completion strobe |
| illegal | output | 1 | Immediate destination rejected |
| res_out | output | 32 | Rotated result, valid while `done` is high |
| cf_out | output | 1 | Carry flag out |
| of_out | output | 1 | Overflow flag out |
| sf_out | output | 1 | Sign flag out |
| pf_out | output | 1 | Parity flag out |
| zf_out | output | 1 | Zero flag out |

## Verification
The bench targets counts larger than a narrow width, such as 31 on a byte. A design that wrapped at bit 31 instead of bit 7 or 15 would return wrong bits there and leave the upper bits nonzero. It applies counts whose low five bits are zero while the upper bits are set: a design that used the full count would run long and rotate. It also covers single-position rotates, which are the only case where overflow changes. Along the way it changes the flag inputs and pulses `start` in the middle of an operation, so a unit that did not capture its inputs or that accepted a second request would return corrupted results. Immediate destinations and zero counts are checked for one-edge completion with every flag untouched.

// File: rtl/rotr_pkg.sv
package rotr_pkg;
    // Shared widths, width-select codes, controller states and flag bundle.
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned CNT_IN_W  = 8;
    localparam int unsigned CNT_W     = 5;
    localparam int unsigned NUM_LANES = 3;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_DONE = 2'b10
    } state_e;

    typedef struct packed {
        logic cf;
        logic of;
        logic sf;
        logic pf;
        logic zf;
    } flags_t;
endpackage

// File: rtl/rotr_ctrl.sv
// Sequencer for the rotate unit. It accepts a request only while idle, derives
// the effective step count (one, or the masked count input), counts steps down,
// and produces the one-cycle done strobe. Assumes start is synchronous to clk.
module rotr_ctrl
    import rotr_pkg::*;
#(
    parameter int unsigned CIN_W = CNT_IN_W,
    parameter int unsigned CW    = CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             by_count,
    input  logic [CIN_W-1:0] cnt_in,
    input  logic             dst_imm,
    output logic             accept,
    output logic             step,
    output logic             single,
    output logic             busy,
    output logic             done,
    output logic             illegal
);
    state_e        state_q;
    logic [CW-1:0] rem_q;
    logic [CW-1:0] eff_cnt;
    logic          illegal_q;
    logic          single_q;
    logic          unused_cnt_hi;

    // Upper count bits are deliberately discarded by the masking rule.
    assign unused_cnt_hi = ^cnt_in[CIN_W-1:CW];

    // Effective amount: a single position or the masked count input.
    always_comb begin
        eff_cnt = by_count ? cnt_in[CW-1:0] : CW'(1);
    end

    assign accept  = start && (state_q == ST_IDLE);
    assign step    = (state_q == ST_RUN);
    assign busy    = (state_q != ST_IDLE);
    assign done    = (state_q == ST_DONE);
    assign illegal = illegal_q;
    assign single  = single_q;

    // State, remaining-step counter and per-operation qualifiers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            rem_q     <= '0;
            illegal_q <= 1'b0;
            single_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        illegal_q <= dst_imm;
                        single_q  <= !dst_imm && (eff_cnt == CW'(1));
                        rem_q     <= eff_cnt;
                        if (dst_imm || (eff_cnt == '0)) begin
                            state_q <= ST_DONE;
                        end else begin
                            state_q <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    rem_q <= rem_q - CW'(1);
                    if (rem_q == CW'(1)) begin
                        state_q <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    state_q   <= ST_IDLE;
                    illegal_q <= 1'b0;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/rotr_datapath.sv
// Operand register and one-position rotator. One lane per supported width is
// generated; the captured width select picks the lane. Bits above the width
// are zero on load and stay zero, since each lane only feeds its own width.
module rotr_datapath
    import rotr_pkg::*;
#(
    parameter int unsigned DW    = DATA_W,
    parameter int unsigned LANES = NUM_LANES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [1:0]    size_sel,
    input  logic [DW-1:0] opnd_in,
    output logic [DW-1:0] data,
    output logic [1:0]    size_cur,
    output logic          out_bit,
    output logic [1:0]    next_top
);
    localparam int unsigned LIDX_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic [DW-1:0]     data_q;
    logic [1:0]        size_q;
    logic [DW-1:0]     lane_step [LANES];
    logic [DW-1:0]     lane_mask [LANES];
    logic [1:0]        lane_top  [LANES];
    logic [LIDX_W-1:0] lane_cur;
    logic [LIDX_W-1:0] lane_new;

    // Map a width-select code onto a lane index (1x selects the widest lane).
    function automatic logic [LIDX_W-1:0] lane_of(input logic [1:0] s);
        case (size_e'(s))
            SZ_BYTE: lane_of = LIDX_W'(0);
            SZ_HALF: lane_of = LIDX_W'(1);
            default: lane_of = LIDX_W'(LANES - 1);
        endcase
    endfunction

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            localparam int unsigned W = 8 << g;
            // One rotate step inside this lane's width, plus its width mask.
            always_comb begin
                lane_step[g] = DW'({data_q[0], data_q[W-1:1]});
                lane_mask[g] = (W >= DW) ? {DW{1'b1}} : DW'({W{1'b1}});
                lane_top[g]  = {data_q[0], data_q[W-1]};
            end
        end
    endgenerate

    assign lane_cur = lane_of(size_q);
    assign lane_new = lane_of(size_sel);

    // The bit about to leave the bottom, and the top two bits after the step.
    always_comb begin
        out_bit  = data_q[0];
        next_top = lane_top[lane_cur];
    end

    // Operand register: load masked operand, or apply one rotate step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            size_q <= 2'b00;
        end else if (load) begin
            data_q <= opnd_in & lane_mask[lane_new];
            size_q <= size_sel;
        end else if (step) begin
            data_q <= lane_step[lane_cur];
        end
    end

    assign data     = data_q;
    assign size_cur = size_q;
endmodule

// File: rtl/rotr_flags.sv
// Flag register. It captures all five flags on load, then on each step writes
// the departing bit into carry. Overflow is updated only when the operation is
// a single position. Sign, parity and zero are never written after load.
module rotr_flags
    import rotr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  flags_t     flags_in,
    input  logic       step,
    input  logic       single,
    input  logic       out_bit,
    input  logic [1:0] next_top,
    output flags_t     flags_out
);
    flags_t flags_q;

    // Capture on load; carry and (single-step) overflow follow each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (load) begin
            flags_q <= flags_in;
        end else if (step) begin
            flags_q.cf <= out_bit;
            if (single) begin
                flags_q.of <= next_top[1] ^ next_top[0];
            end
        end
    end

    assign flags_out = flags_q;
endmodule

// File: rtl/rotr_seq_unit.sv
// Top of the sequential rotate-right unit: controller, operand datapath and
// flag register. Outputs are registered and hold their value while done is
// high; during the run the result port shows intermediate steps.
module rotr_seq_unit
    import rotr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] opnd_in,
    input  logic [1:0]  size_sel,
    input  logic        by_count,
    input  logic [7:0]  cnt_in,
    input  logic        dst_imm,
    input  logic        cf_in,
    input  logic        of_in,
    input  logic        sf_in,
    input  logic        pf_in,
    input  logic        zf_in,
    output logic        busy,
    output logic        done,
    output logic        illegal,
    output logic [31:0] res_out,
    output logic        cf_out,
    output logic        of_out,
    output logic        sf_out,
    output logic        pf_out,
    output logic        zf_out
);
    logic       accept;
    logic       step;
    logic       single;
    logic       out_bit;
    logic [1:0] next_top;
    logic [1:0] size_cur;
    flags_t     flags_in;
    flags_t     flags_q;

    assign flags_in = '{cf: cf_in, of: of_in, sf: sf_in, pf: pf_in, zf: zf_in};

    rotr_ctrl #(.CIN_W(CNT_IN_W), .CW(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .by_count (by_count),
        .cnt_in   (cnt_in),
        .dst_imm  (dst_imm),
        .accept   (accept),
        .step     (step),
        .single   (single),
        .busy     (busy),
        .done     (done),
        .illegal  (illegal)
    );

    rotr_datapath #(.DW(DATA_W), .LANES(NUM_LANES)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .step     (step),
        .size_sel (size_sel),
        .opnd_in  (opnd_in),
        .data     (res_out),
        .size_cur (size_cur),
        .out_bit  (out_bit),
        .next_top (next_top)
    );

    rotr_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .flags_in  (flags_in),
        .step      (step),
        .single    (single),
        .out_bit   (out_bit),
        .next_top  (next_top),
        .flags_out (flags_q)
    );

    assign cf_out = flags_q.cf;
    assign of_out = flags_q.of;
    assign sf_out = flags_q.sf;
    assign pf_out = flags_q.pf;
    assign zf_out = flags_q.zf;
endmodule

// File: rtl/rotr_seq_unit_chk.sv
// Protocol and invariant checks for rotr_seq_unit, attached by bind.
module rotr_seq_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        dst_imm,
    input logic        busy,
    input logic        done,
    input logic        illegal,
    input logic [31:0] res_out,
    input logic [1:0]  size_cur,
    input logic        sf_out,
    input logic        pf_out,
    input logic        zf_out
);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    imm_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && dst_imm) |=> (done && illegal));

    // R10
    illegal_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> done);

    // R5
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable({sf_out, pf_out, zf_out}));

    // R6
    narrow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (size_cur == 2'b00)) |-> (res_out[31:8] == 24'h0));

    // R6
    half_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (size_cur == 2'b01)) |-> (res_out[31:16] == 16'h0));

    // R9
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

bind rotr_seq_unit rotr_seq_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .dst_imm  (dst_imm),
    .busy     (busy),
    .done     (done),
    .illegal  (illegal),
    .res_out  (res_out),
    .size_cur (size_cur),
    .sf_out   (sf_out),
    .pf_out   (pf_out),
    .zf_out   (zf_out)
);

// File: tb/rotr_seq_unit_test.sv
module rotr_seq_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] opnd_in = '0;
    logic [1:0]  size_sel = '0;
    logic        by_count = 1'b0;
    logic [7:0]  cnt_in = '0;
    logic        dst_imm = 1'b0;
    logic        cf_in = 1'b0, of_in = 1'b0, sf_in = 1'b0, pf_in = 1'b0, zf_in = 1'b0;
    logic        busy, done, illegal;
    logic [31:0] res_out;
    logic        cf_out, of_out, sf_out, pf_out, zf_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    rotr_seq_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .opnd_in(opnd_in),
        .size_sel(size_sel), .by_count(by_count), .cnt_in(cnt_in),
        .dst_imm(dst_imm), .cf_in(cf_in), .of_in(of_in), .sf_in(sf_in),
        .pf_in(pf_in), .zf_in(zf_in), .busy(busy), .done(done),
        .illegal(illegal), .res_out(res_out), .cf_out(cf_out),
        .of_out(of_out), .sf_out(sf_out), .pf_out(pf_out), .zf_out(zf_out)
    );

    always #5 clk = ~clk;

    // Watchdog: an overrun counts as a failed check and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: act %0d cycles exp < 150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: act %h exp %h", req, what, act, exp);
        end
    endtask

    function automatic int width_of(input logic [1:0] s);
        return (s == 2'b00) ? 8 : (s == 2'b01) ? 16 : 32;
    endfunction

    function automatic logic [31:0] limit(input logic [31:0] v, input int w);
        return (w == 32) ? v : (v & ((32'h1 << w) - 1));
    endfunction

    function automatic logic [31:0] ref_rot(input logic [31:0] v, input int w, input int n);
        logic [31:0] r;
        logic        b;
        r = limit(v, w);
        for (int i = 0; i < n; i++) begin
            b = r[0];
            r = r >> 1;
            r[w-1] = b;
        end
        return r;
    endfunction

    // One operation: flags fl = {cf, of, sf, pf, zf}; poke = extra start mid-run.
    task automatic do_op(input logic [31:0] op, input logic [1:0] sz, input bit mode,
                         input logic [7:0] cnt, input bit imm, input logic [4:0] fl,
                         input bit poke);
        int          w, n, cycles;
        logic [31:0] er;
        logic        ecf, eof;
        w  = width_of(sz);
        n  = imm ? 0 : (mode ? int'(cnt[4:0]) : 1);
        er = imm ? limit(op, w) : ref_rot(op, w, n);
        ecf = (imm || n == 0) ? fl[4] : er[w-1];
        eof = (!imm && n == 1) ? (er[w-1] ^ er[w-2]) : fl[3];

        @(negedge clk);
        opnd_in = op; size_sel = sz; by_count = mode; cnt_in = cnt; dst_imm = imm;
        {cf_in, of_in, sf_in, pf_in, zf_in} = fl;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // Disturb every input after capture (R5, R9).
        opnd_in = ~op; size_sel = ~sz; cnt_in = ~cnt; by_count = ~mode;
        {cf_in, of_in, sf_in, pf_in, zf_in} = ~fl;
        cycles = 0;
        while (!done && cycles < 60) begin
            @(negedge clk);
            cycles++;
            if (poke && cycles == 1 && !done) begin
                start = 1'b1; dst_imm = 1'b1;
            end else begin
                start = 1'b0; dst_imm = 1'b0;
            end
        end
        start = 1'b0;
        check(cycles == n, (n == 0) ? "R7" : "R8", "latency", cycles, n);
        check(done == 1'b1, "R8", "done seen", done, 1);
        check(res_out == er, imm ? "R10" : (n == 0 ? "R7" : "R1"), "result", res_out, er);
        check(cf_out == ecf, "R3", "carry", cf_out, ecf);
        check(of_out == eof, "R4", "overflow", of_out, eof);
        check({sf_out, pf_out, zf_out} == fl[2:0], "R5", "sf/pf/zf", {sf_out, pf_out, zf_out}, fl[2:0]);
        check(illegal == imm, "R10", "illegal", illegal, imm);
        if (w < 32) check(res_out >> w == 0, "R6", "upper bits", res_out >> w, 0);
        @(negedge clk);
        check(done == 1'b0, "R8", "done one cycle", done, 0);
        check(busy == 1'b0, "R9", "busy released", busy, 0);
    endtask

    initial begin
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(!busy && !done && !illegal, "R11", "ctrl after reset", {busy, done, illegal}, 0);
        check(res_out == 0, "R11", "result after reset", res_out, 0);
        check({cf_out, of_out, sf_out, pf_out, zf_out} == 0, "R11", "flags after reset",
              {cf_out, of_out, sf_out, pf_out, zf_out}, 0);

        // R1 R4: byte, single position, overflow recomputed
        do_op(32'h0000_0081, 2'b00, 1'b0, 8'd9, 1'b0, 5'b01010, 1'b0);
        // R2: single-position mode ignores cnt_in
        do_op(32'h1234_5678, 2'b10, 1'b0, 8'd17, 1'b0, 5'b10101, 1'b0);
        // R2 R7: masked count zero (0x20 -> 0)
        do_op(32'hdead_beef, 2'b01, 1'b1, 8'h20, 1'b0, 5'b11111, 1'b0);
        // R2: upper count bits ignored (0xE3 -> 3)
        do_op(32'h0000_00f1, 2'b00, 1'b1, 8'he3, 1'b0, 5'b00000, 1'b1);
        // R6: count 31 on a byte wraps at bit 7
        do_op(32'hffff_ff01, 2'b00, 1'b1, 8'd31, 1'b0, 5'b01001, 1'b1);
        // R6: count 31 on a half-word, size 11 as a word
        do_op(32'h8001_0001, 2'b01, 1'b1, 8'd31, 1'b0, 5'b00110, 1'b1);
        do_op(32'h8000_0001, 2'b11, 1'b1, 8'd31, 1'b0, 5'b11000, 1'b1);
        // R10: immediate destination rejected
        do_op(32'hcafe_f00d, 2'b10, 1'b1, 8'd5, 1'b1, 5'b10110, 1'b0);
        do_op(32'hcafe_f00d, 2'b00, 1'b0, 8'd0, 1'b1, 5'b01101, 1'b0);
        // R3: count 1 on a half-word with the lsb set
        do_op(32'h0000_4001, 2'b01, 1'b1, 8'd1, 1'b0, 5'b00000, 1'b0);

        // Random mix
        for (int k = 0; k < 250; k++) begin
            do_op($urandom, 2'($urandom), 1'($urandom), 8'($urandom),
                  ($urandom % 16) == 0, 5'($urandom), 1'($urandom));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule